// File: doc/BRIEF.md
# Parallel Codeword Assembly Buffer

This block gathers the symbols of fixed-length codewords, together with a per-symbol erasure flag, when they arrive a few at a time. Every input beat carries PAR symbols of M bits for each of C channels. The channels run side by side and share one handshake. After ceil(N/PAR) accepted beats, the block presents a whole N-symbol word per channel with an N-bit erasure mask. A downstream erasure decoder can then work on a complete word in a single cycle.

The interface has no start or end markers. The block finds word boundaries by counting accepted beats. Erased symbols are forced to zero as they are captured. The finished word sits in a one-deep output register. The input follows valid/ready rules with zero ready latency: a beat moves only on a cycle where `in_valid` and `in_ready` are both high. The output offers its word until `out_ready` takes it. While the output register holds a word that is not being drained, `in_ready` stays low, so back-pressure reaches the source on the same cycle.

Top module: `cw_assembler`

## Requirements
- R1: Within a beat, the symbol of lane l for channel c is `in_data[(c*PAR+l)*M +: M]`, and its erasure flag is `in_era[c*PAR+l]`.
- R2: A beat is consumed only on a rising edge where `in_valid` and `in_ready` are both high. On any other edge the input is ignored and the beat position does not move.
- R3: Every ceil(N/PAR) consumed beats complete one word. `out_valid` rises on the edge that consumes the final beat.
- R4: Symbols keep their arrival order. Word position j comes from beat j/PAR, lane j%PAR, and appears at `out_data[(c*N+j)*M +: M]`.
- R5: A symbol whose erasure flag is 1 appears as zero in `out_data`. Its flag is reported at `out_era[c*N+j]`.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_era` hold steady.
- R7: `in_ready` is high exactly when the output register is empty or is being drained on that cycle (`!out_valid || out_ready`).
- R8: When N is not a multiple of PAR, the unused lanes of the final beat (lane ≥ N-(ceil(N/PAR)-1)*PAR) do not affect the word. The next word starts with lane 0 of the following beat.
- R9: The active-low reset clears `out_valid` and returns the beat position to a word boundary. A partly gathered word is discarded.
- R10: The channels are independent: the data and flags of one channel never appear in another channel's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| in_valid | input | 1 | Source offers a beat |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | C*PAR*M | Symbols of one beat, all channels |
| in_era | input | C*PAR | Erasure flags of one beat |
| out_valid | output | 1 | A complete word is presented |
| out_ready | input | 1 | Sink takes the word this cycle |
| out_data | output | C*N*M | Assembled words, erased symbols zeroed |
| out_era | output | C*N | Erasure masks of the assembled words |

## Verification
On every cycle the assertions check four things: the beat position stays in range and freezes when no beat is consumed; a finished word never lands on an occupied, undrained output register; a stalled word holds still; and every flagged position reads zero. Other behaviours need the bench's scenarios. These are symbol ordering across beats, the ignored surplus lanes of the final beat, separation between channels, and the loss of a partial word on reset. A behavioural model checks these against the outputs every cycle under random valid and ready patterns, and directed words check chosen positions.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cwa_count.sv
module cwa_count #(
  parameter int BEATS = 4,
  localparam int CW = cwa_pkg::cnt_width(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic [CW-1:0] beat,
  output logic          last
);
  localparam logic [CW-1:0] LAST_B = CW'(BEATS - 1);

  assign last = (beat == LAST_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat <= '0;
    else if (take)  beat <= last ? '0 : beat + 1'b1;
  end

  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    beat <= LAST_B);                                            // R3
  AST_BEAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(beat));                                   // R2
endmodule

// File: rtl/cwa_lane.sv
module cwa_lane #(
  parameter int PAR   = 4,
  parameter int N     = 14,
  parameter int M     = 4,
  parameter int BEATS = 4,
  localparam int CW   = cwa_pkg::cnt_width(BEATS),
  localparam int STG  = (BEATS - 1) * PAR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [CW-1:0]  beat,
  input  logic [PAR*M-1:0] sym_in,
  input  logic [PAR-1:0] era_in,
  output logic [N*M-1:0] word_out,
  output logic [N-1:0]   mask_out
);
  logic [PAR*M-1:0] clean;

  for (genvar l = 0; l < PAR; l++) begin : g_mask
    assign clean[l*M +: M] = era_in[l] ? '0 : sym_in[l*M +: M];
  end

  if (BEATS > 1) begin : g_stage
    logic [STG*M-1:0] stg_d;
    logic [STG-1:0]   stg_e;
    for (genvar k = 0; k < BEATS - 1; k++) begin : g_beat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_d[k*PAR*M +: PAR*M] <= '0;
          stg_e[k*PAR +: PAR]     <= '0;
        end else if (take && beat == CW'(k)) begin
          stg_d[k*PAR*M +: PAR*M] <= clean;
          stg_e[k*PAR +: PAR]     <= era_in;
        end
      end
    end
    for (genvar j = 0; j < N; j++) begin : g_pos
      if (j < STG) begin : g_old
        assign word_out[j*M +: M] = stg_d[j*M +: M];
        assign mask_out[j]        = stg_e[j];
      end else begin : g_new
        assign word_out[j*M +: M] = clean[(j-STG)*M +: M];
        assign mask_out[j]        = era_in[j-STG];
      end
    end
  end else begin : g_direct
    for (genvar j = 0; j < N; j++) begin : g_pos
      assign word_out[j*M +: M] = clean[j*M +: M];
      assign mask_out[j]        = era_in[j];
    end
  end
endmodule

// File: rtl/cwa_outreg.sv
module cwa_outreg #(
  parameter int SYMS = 28,
  parameter int M    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SYMS*M-1:0] d_in,
  input  logic [SYMS-1:0]   e_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [SYMS*M-1:0] out_data,
  output logic [SYMS-1:0]   out_era
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_era   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d_in;
      out_era   <= e_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));                        // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_era))); // R6

  for (genvar i = 0; i < SYMS; i++) begin : g_chk
    AST_ERASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_era[i]) |-> (out_data[i*M +: M] == '0)); // R5
  end
endmodule

// File: rtl/cw_assembler.sv
module cw_assembler #(
  parameter int C   = 2,
  parameter int PAR = 4,
  parameter int N   = 14,
  parameter int M   = 4,
  localparam int BEATS = cwa_pkg::ceil_div(N, PAR),
  localparam int CW    = cwa_pkg::cnt_width(BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [C*PAR*M-1:0] in_data,
  input  logic [C*PAR-1:0]   in_era,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [C*N*M-1:0]   out_data,
  output logic [C*N-1:0]     out_era
);
  logic          take;
  logic          last;
  logic [CW-1:0] beat;
  logic [C*N*M-1:0] word_all;
  logic [C*N-1:0]   mask_all;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  cwa_count #(.BEATS(BEATS)) u_count (
    .clk(clk), .rst_n(rst_n), .take(take), .beat(beat), .last(last)
  );

  for (genvar c = 0; c < C; c++) begin : g_ch
    cwa_lane #(.PAR(PAR), .N(N), .M(M), .BEATS(BEATS)) u_lane (
      .clk(clk), .rst_n(rst_n), .take(take), .beat(beat),
      .sym_in(in_data[c*PAR*M +: PAR*M]),
      .era_in(in_era[c*PAR +: PAR]),
      .word_out(word_all[c*N*M +: N*M]),
      .mask_out(mask_all[c*N +: N])
    );
  end

  cwa_outreg #(.SYMS(C*N), .M(M)) u_out (
    .clk(clk), .rst_n(rst_n), .load(take && last),
    .d_in(word_all), .e_in(mask_all), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_era(out_era)
  );
endmodule

// File: tb/cw_assembler_test.sv
`timescale 1ns/100ps
module cw_assembler_test;
  localparam int C = 2, PAR = 4, N = 14, M = 4;
  localparam int BEATS = (N + PAR - 1) / PAR;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [C*PAR*M-1:0] in_data = '0;
  logic [C*PAR-1:0]   in_era = '0;
  logic in_ready, out_valid;
  logic [C*N*M-1:0] out_data;
  logic [C*N-1:0]   out_era;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cw_assembler #(.C(C), .PAR(PAR), .N(N), .M(M)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_era(in_era), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_era(out_era)
  );

  // behavioural reference model
  logic [M-1:0] acc [C][N];
  bit           acce [C][N];
  bit           m_valid = 0;
  logic [C*N*M-1:0] m_data = '0;
  logic [C*N-1:0]   m_era = '0;
  int           m_beat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_beat = 0;
    end else begin
      bit took;
      took = in_valid && (!m_valid || out_ready);
      if (m_valid && out_ready) m_valid = 0;
      if (took) begin
        for (int c = 0; c < C; c++)
          for (int l = 0; l < PAR; l++) begin
            int pos;
            pos = m_beat * PAR + l;
            if (pos < N) begin
              acce[c][pos] = in_era[c*PAR+l];
              acc[c][pos]  = in_era[c*PAR+l] ? '0 : in_data[(c*PAR+l)*M +: M];
            end
          end
        m_beat++;
        if (m_beat == BEATS) begin
          m_beat = 0; m_valid = 1;
          for (int c = 0; c < C; c++)
            for (int j = 0; j < N; j++) begin
              m_data[(c*N+j)*M +: M] = acc[c][j];
              m_era[c*N+j] = acce[c][j];
            end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(out_valid == m_valid, "R3", "out_valid", 128'(out_valid), 128'(m_valid));
      chk(in_ready == (!m_valid || out_ready), "R7", "in_ready",
          128'(in_ready), 128'(!m_valid || out_ready));
      if (m_valid) begin
        chk(out_data == m_data, "R4", "out_data", 128'(out_data), 128'(m_data));
        chk(out_era == m_era, "R5", "out_era", 128'(out_era), 128'(m_era));
      end
    end
  end

  task automatic send_beat(input logic [C*PAR*M-1:0] d, input logic [C*PAR-1:0] e);
    @(negedge clk);
    in_valid = 1; in_data = d; in_era = e;
    forever begin
      #1;
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_data = '1; in_era = '1;
  endtask

  // ch0 symbol = pos+off, ch1 = 15-pos; ch0 erased at erapos; surplus lanes F and flagged (R1, R8)
  task automatic send_word(input int off, input int erapos, input int nbeats);
    for (int b = 0; b < nbeats; b++) begin
      logic [C*PAR*M-1:0] d;
      logic [C*PAR-1:0]   e;
      for (int c = 0; c < C; c++)
        for (int l = 0; l < PAR; l++) begin
          int pos;
          pos = b * PAR + l;
          if (pos < N) begin
            d[(c*PAR+l)*M +: M] = (c == 0) ? M'(pos + off) : M'(15 - pos);
            e[c*PAR+l] = (c == 0 && pos == erapos);
          end else begin
            d[(c*PAR+l)*M +: M] = '1;
            e[c*PAR+l] = 1'b1;
          end
        end
      send_beat(d, e);
    end
  endtask

  function automatic logic [M-1:0] sym(input int c, input int j);
    return out_data[(c*N+j)*M +: M];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [C*N*M-1:0] held;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R9", "reset out_valid", 128'(out_valid), 0);
    chk(in_ready == 1, "R9", "reset in_ready", 128'(in_ready), 1);
    @(negedge clk); rst_n = 1;

    // R2: garbage without valid must not advance
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_data = 32'($urandom); in_era = 8'($urandom);
    end
    #1; chk(out_valid == 0, "R2", "idle beats ignored", 128'(out_valid), 0);

    // directed word, sink stalled
    out_ready = 0;
    send_word(1, 3, BEATS);
    #1;
    chk(out_valid == 1, "R3", "word complete", 128'(out_valid), 1);
    chk(sym(0, 3) == 0, "R5", "erased ch0 pos3", 128'(sym(0, 3)), 0);
    chk(sym(0, 13) == 4'hE, "R4", "ch0 pos13", 128'(sym(0, 13)), 128'hE);
    chk(sym(0, 4) == 4'h5, "R1", "ch0 pos4 lane0 beat1", 128'(sym(0, 4)), 128'h5);
    chk(out_era[13:0] == 14'h0008, "R8", "ch0 mask, surplus ignored", 128'(out_era[13:0]), 128'h8);
    chk(out_era[27:14] == 14'h0, "R10", "ch1 mask", 128'(out_era[27:14]), 0);
    chk(sym(1, 0) == 4'hF, "R10", "ch1 pos0", 128'(sym(1, 0)), 128'hF);
    chk(in_ready == 0, "R7", "ready low while full", 128'(in_ready), 0);
    held = out_data;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1 && out_data == held, "R6", "stall hold", 128'(out_data), 128'(held));
    @(negedge clk); out_ready = 1;
    @(negedge clk); #1;
    chk(out_valid == 0, "R3", "drained", 128'(out_valid), 0);

    // second word starts on a fresh beat (R8)
    send_word(2, 20, BEATS);
    #1;
    chk(sym(0, 0) == 4'h2, "R8", "next word lane0", 128'(sym(0, 0)), 128'h2);

    // R9: reset mid-word discards partial word
    send_word(5, 20, 2);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    send_word(1, 20, 2);
    #1;
    chk(out_valid == 0, "R9", "partial discarded", 128'(out_valid), 0);
    send_word(1, 20, BEATS - 2);
    #1;
    chk(out_valid == 1 && sym(0, 0) == 4'h1, "R9", "restart at boundary", 128'(sym(0, 0)), 128'h1);

    // random traffic compared with the model every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      in_valid  = ($urandom % 3) != 0;
      in_data   = 32'($urandom);
      in_era    = 8'($urandom & $urandom);
      out_ready = ($urandom % 4) != 0;
    end
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule